// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block drives the digital side of a dot-matrix LCD with 16 common lines and 60 segment lines. It holds a 120-byte display memory and walks the commons one at a time. For the active common it presents a select or non-select bit on every segment. A registered timer advances the scan, and that timer moves only on a 32.768 kHz tick enable. The external bias stage turns the outputs into analog levels. It uses the common index, the segment bits and a frame-phase bit that flips once per full pass, so it can alternate the drive polarity.

A host writes the display memory through a 7-bit address and 8-bit data port at any time. Reads return data only while the display is switched off. A 2-bit control field picks one of three states: off, blanked or displaying. A mode bit picks 1/16 or 1/8 duty, and the block takes that bit in only while the display is off. When key scanning is enabled, the block forces all segment outputs low for the first tick of every common period and flags that window, so an external keyboard matrix can be probed.

Top module: `lcd_scan_top`

## Requirements
- R1: Control field `disp_ctrl_i` is decoded as follows. 2'b00 means off: `com_act_o` is low, and at the next clock the tick counter, the common index and the frame bit return to 0. 2'b11 means displaying. 2'b01 and 2'b10 mean blanked. In both the blanked and displaying states `com_act_o` is high.
- R2: While the display is not in the displaying state (2'b11), every bit of `seg_o` is 0 (non-select), and the commons keep scanning whenever the state is not off.
- R3: `duty_half_i`=0 selects 1/16 duty (commons 0..15) and 1 selects 1/8 duty (commons 0..7, so 8..15 are never shown). The bit is captured on each clock edge while the state is off and is held otherwise. After reset the duty is 1/16.
- R4: In the displaying state, `seg_o[n]` equals bit c of byte address n when the active common c is below 8. For c of 8 or more it equals bit c-8 of address 0x40+n. Bit 7 maps to the highest common of each half. A 1 selects and a 0 does not.
- R5: Addresses whose low six bits are 60..63 (0x3C..0x3F, 0x7C..0x7F) hold nothing. Writes to them are ignored and reads return 0.
- R6: A read (`host_re_i`) captured while the state is off puts the addressed byte on `host_rdata_o` at the next clock. Any other cycle, including a read attempted while the display is blanked or on, loads 0.
- R7: A write is accepted in every display state and shows on `seg_o` and on later reads from the next clock onward. When a read and a write hit the same address in the same cycle, the read returns the old byte.
- R8: The scan advances only on cycles with `tick_i` high. A common period lasts TICKS_PER_COM ticks (default 4). After its last tick the common index steps by one, and after the last common it wraps to 0.
- R9: `frame_o` inverts on the tick that wraps the common index from the last common back to 0.
- R10: With `key_scan_en_i` high and the state not off, `key_low_o` is high while the tick counter is 0, which is the first tick of each common period. During that window every bit of `seg_o` is 0.
- R11: After reset, the common index, `frame_o`, `host_rdata_o` and all display bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz time-base enable, one clock wide |
| disp_ctrl_i | input | 2 | Display state: 00 off, 01/10 blanked, 11 displaying |
| duty_half_i | input | 1 | 0 = 1/16 duty, 1 = 1/8 duty (taken while off) |
| key_scan_en_i | input | 1 | Enables the key-scan low window |
| host_we_i | input | 1 | Display memory write strobe |
| host_re_i | input | 1 | Display memory read strobe |
| host_addr_i | input | 7 | Display memory byte address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, one clock after the strobe |
| com_idx_o | output | 4 | Index of the active common |
| com_act_o | output | 1 | High when a common is being driven |
| seg_o | output | 60 | Select (1) / non-select (0) per segment |
| frame_o | output | 1 | Frame phase for AC drive |
| key_low_o | output | 1 | Key-scan low window active |

## Verification
Two events can coincide in one cycle. One is a host write to the byte currently shown. The other is the tick that moves the scan to the next common, possibly wrapping the frame. The bench provokes this by writing segment bytes while ticks arrive every cycle. It also lands a same-address read and write in one cycle while the display is off. A behavioural reference model holds its own memory array and integer counters, and the bench compares every output against it on every clock. In this way a write must become visible on exactly the next cycle, for whichever common the tick has just selected. A same-cycle read must return the pre-write byte.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    DISP_OFF   = 2'b00,
    DISP_BLNKA = 2'b01,
    DISP_BLNKB = 2'b10,
    DISP_ON    = 2'b11
  } disp_state_e;

  function automatic logic is_off(input logic [1:0] c);
    return disp_state_e'(c) == DISP_OFF;
  endfunction

  function automatic logic is_on(input logic [1:0] c);
    return disp_state_e'(c) == DISP_ON;
  endfunction
endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int NUM_SEG = 60,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  localparam int CW     = $clog2(2*DATA_W),
  localparam int SW     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              rd_allow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CW-1:0]     com_i,
  output logic [NUM_SEG-1:0] col_o
);
  localparam int RW = ADDR_W - 1;

  logic [DATA_W-1:0] lo_q [NUM_SEG];
  logic [DATA_W-1:0] hi_q [NUM_SEG];
  logic [DATA_W-1:0] rdata_q;
  logic              half;
  logic [RW-1:0]     row;
  logic              row_ok;

  assign half   = addr_i[ADDR_W-1];
  assign row    = addr_i[RW-1:0];
  assign row_ok = 32'(row) < NUM_SEG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
      rdata_q <= '0;
    end else begin
      if (we_i && row_ok) begin
        if (half) hi_q[row] <= wdata_i;
        else      lo_q[row] <= wdata_i;
      end
      // read sees pre-write contents; blocked reads load zero
      if (re_i && rd_allow_i && row_ok) rdata_q <= half ? hi_q[row] : lo_q[row];
      else                              rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  // column bit of each segment for the active common
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_col
    assign col_o[g] = com_i[CW-1] ? hi_q[g][com_i[SW-1:0]] : lo_q[g][com_i[SW-1:0]];
  end

  assert_read_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !rd_allow_i) |=> rdata_o == '0);
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int NUM_COM       = 16,
  parameter int TICKS_PER_COM = 4,
  localparam int CW           = $clog2(NUM_COM),
  localparam int TW           = (TICKS_PER_COM > 1) ? $clog2(TICKS_PER_COM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          off_i,
  input  logic          duty_half_i,
  output logic [CW-1:0] com_o,
  output logic          first_tick_o,
  output logic          frame_o
);
  logic [TW-1:0] tcnt_q;
  logic [CW-1:0] com_q;
  logic          frame_q;
  logic          duty_q;
  logic [CW-1:0] last;
  logic          per_end;

  assign last    = duty_q ? CW'(NUM_COM/2 - 1) : CW'(NUM_COM - 1);
  assign per_end = tcnt_q == TW'(TICKS_PER_COM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      com_q   <= '0;
      frame_q <= 1'b0;
      duty_q  <= 1'b0;
    end else if (off_i) begin
      duty_q  <= duty_half_i;
      tcnt_q  <= '0;
      com_q   <= '0;
      frame_q <= 1'b0;
    end else if (tick_i) begin
      if (per_end) begin
        tcnt_q <= '0;
        if (com_q == last) begin
          com_q   <= '0;
          frame_q <= ~frame_q;
        end else begin
          com_q <= com_q + 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign com_o        = com_q;
  assign first_tick_o = tcnt_q == '0;
  assign frame_o      = frame_q;

  assert_com_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_q <= last);
  assert_duty_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_i |=> $stable(duty_q));
  assert_off_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> (com_q == '0 && tcnt_q == '0 && !frame_q));
  assert_frame_on_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_i && tick_i && per_end && com_q == last) |=> frame_q != $past(frame_q));
  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_i && !tick_i) |=> ($stable(com_q) && $stable(tcnt_q)));
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
  parameter int NUM_SEG = 60
) (
  input  logic [NUM_SEG-1:0] col_i,
  input  logic               on_i,
  input  logic               key_low_i,
  output logic [NUM_SEG-1:0] seg_o
);
  assign seg_o = (on_i && !key_low_i) ? col_i : '0;
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG       = 60,
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 7,
  parameter int TICKS_PER_COM = 4,
  localparam int NUM_COM      = 2*DATA_W,
  localparam int CW           = $clog2(NUM_COM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [1:0]         disp_ctrl_i,
  input  logic               duty_half_i,
  input  logic               key_scan_en_i,
  input  logic               host_we_i,
  input  logic               host_re_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic [CW-1:0]      com_idx_o,
  output logic               com_act_o,
  output logic [NUM_SEG-1:0] seg_o,
  output logic               frame_o,
  output logic               key_low_o
);
  logic              off;
  logic              on;
  logic [CW-1:0]     com;
  logic              first_tick;
  logic [NUM_SEG-1:0] col;

  assign off = is_off(disp_ctrl_i);
  assign on  = is_on(disp_ctrl_i);

  lcd_disp_ram #(.NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i      (host_we_i),
    .re_i      (host_re_i),
    .rd_allow_i(off),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .rdata_o   (host_rdata_o),
    .com_i     (com),
    .col_o     (col)
  );

  lcd_scan_timer #(.NUM_COM(NUM_COM), .TICKS_PER_COM(TICKS_PER_COM)) u_timer (
    .clk_i, .rst_ni,
    .tick_i,
    .off_i       (off),
    .duty_half_i,
    .com_o       (com),
    .first_tick_o(first_tick),
    .frame_o
  );

  assign key_low_o = key_scan_en_i && first_tick && !off;

  lcd_seg_drive #(.NUM_SEG(NUM_SEG)) u_drive (
    .col_i    (col),
    .on_i     (on),
    .key_low_i(key_low_o),
    .seg_o
  );

  assign com_idx_o = com;
  assign com_act_o = !off;

  assert_blank_nonsel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |-> seg_o == '0);
  assert_key_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_low_o |-> seg_o == '0);
  assert_off_inactive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off |-> !com_act_o && !key_low_o);
endmodule

// File: tb/lcd_scan_top_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_top_tb_top;
  localparam int TPC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  ctrl = 2'b00;
  logic        duty8 = 1'b0;
  logic        ks_en = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  com_idx;
  logic        com_act;
  logic [59:0] seg;
  logic        frame;
  logic        key_low;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tick_div = 1;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_scan_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .disp_ctrl_i(ctrl),
    .duty_half_i(duty8), .key_scan_en_i(ks_en), .host_we_i(we), .host_re_i(re),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .com_idx_o(com_idx), .com_act_o(com_act), .seg_o(seg), .frame_o(frame),
    .key_low_o(key_low)
  );

  // reference model
  logic [7:0] mm [128];
  int m_tcnt, m_com, m_frame, m_duty;
  logic [7:0] m_rd;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mm[i] = 8'h00;
      m_tcnt = 0; m_com = 0; m_frame = 0; m_duty = 0; m_rd = 8'h00;
    end else begin
      m_rd = (re && ctrl == 2'b00 && addr[5:0] < 60) ? mm[addr] : 8'h00;
      if (we && addr[5:0] < 60) mm[addr] = wdata;
      if (ctrl == 2'b00) begin
        m_duty = duty8; m_tcnt = 0; m_com = 0; m_frame = 0;
      end else if (tick) begin
        if (m_tcnt == TPC-1) begin
          m_tcnt = 0;
          if (m_com == (m_duty ? 7 : 15)) begin m_com = 0; m_frame ^= 1; end
          else m_com++;
        end else m_tcnt++;
      end
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && !done) begin
      logic        e_key;
      logic [59:0] e_seg;
      string       stag;
      e_key = ks_en && m_tcnt == 0 && ctrl != 2'b00;
      for (int n = 0; n < 60; n++)
        e_seg[n] = (m_com < 8) ? mm[n][m_com] : mm[64+n][m_com-8];
      if (ctrl != 2'b11 || e_key) e_seg = '0;
      stag = e_key ? "R10" : (ctrl != 2'b11) ? "R2" : m_duty ? "R3" : "R4";
      chk("R1", 64'(com_act), 64'(ctrl != 2'b00));
      chk("R8", 64'(com_idx), 64'(m_com));
      chk(stag, 64'(seg), 64'(e_seg));
      chk("R9", 64'(frame), 64'(m_frame));
      chk("R10", 64'(key_low), 64'(e_key));
      chk("R6", 64'(rdata), 64'(m_rd));
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) tick <= ((cyc % tick_div) == 0);

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d; re = 0;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_expect(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); re = 1; addr = a; we = 0;
    @(negedge clk); re = 0;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R11: reset values
    run(3);
    chk("R11", 64'(com_idx), 64'd0);
    chk("R11", 64'(frame), 64'd0);
    chk("R11", 64'(rdata), 64'd0);
    chk("R11", 64'(seg), 64'd0);
    rst_n = 1;
    run(2);
    rd_expect("R11", 7'h05, 8'h00);
    rd_expect("R11", 7'h45, 8'h00);

    for (int n = 0; n < 60; n++) begin
      wr(7'(n), 8'((n*37 + 11) & 255));
      wr(7'(64+n), 8'((n*91 + 5) & 255));
    end
    // R5: unused locations
    wr(7'h3C, 8'hAA);
    wr(7'h7F, 8'h55);
    rd_expect("R5", 7'h3C, 8'h00);
    rd_expect("R5", 7'h7F, 8'h00);
    rd_expect("R6", 7'h02, 8'((2*37 + 11) & 255));
    rd_expect("R6", 7'h43, 8'((3*91 + 5) & 255));

    // R7: same-cycle read and write returns old byte
    @(negedge clk); we = 1; re = 1; addr = 7'h10; wdata = 8'h3C;
    @(negedge clk); we = 0; re = 0;
    chk("R7", 64'(rdata), 64'((16*37 + 11) & 255));
    rd_expect("R7", 7'h10, 8'h3C);

    // displaying, 1/16 duty, tick every cycle with live writes
    ctrl = 2'b11;
    for (int k = 0; k < 40; k++) begin
      wr(7'(k % 60), 8'(k*13));
      wr(7'(64 + (k*7) % 60), 8'(~(k*5)));
    end
    run(100);
    // R6: read while on returns zero
    rd_expect("R6", 7'h01, 8'h00);

    // slower tick
    tick_div = 3;
    run(250);
    tick_div = 1;

    // blanked states
    ctrl = 2'b01; run(80);
    ctrl = 2'b10; run(40);
    rd_expect("R6", 7'h01, 8'h00);

    // key scan
    ctrl = 2'b11; ks_en = 1; run(100);
    ctrl = 2'b01; run(30);

    // R3: duty request while on is ignored
    ctrl = 2'b11; ks_en = 0; duty8 = 1; run(100);
    ctrl = 2'b00; run(1);
    ctrl = 2'b11; run(150);
    ks_en = 1; run(60);
    ks_en = 0;

    // R8: no ticks, no movement
    tick_div = 1000000; run(30);
    tick_div = 1; run(20);

    // R7: write while on is kept
    wr(7'h05, 8'hE7);
    ctrl = 2'b00; duty8 = 0; run(2);
    rd_expect("R7", 7'h05, 8'hE7);
    ctrl = 2'b11; run(100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule